// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write-Protected Control

This block is a watchdog built around one counter running on the timer clock. Software sets it up through a single 32-bit control word. The enable, the interrupt enable, the reset enable and the restart bit are write-protected. They accept new values only while the external `unlock` level is high. The two status flags are exempt from this protection and can always be cleared.

When enabled, the counter first measures an interval. Its length is a power of two, chosen by a 3-bit exponent code. When the interval ends, the interrupt flag sets. The interrupt output follows that flag only when interrupts are enabled.

The second stage is a fixed grace window that begins at the end of the interval. If software has not restarted the counter by the end of the window, the block issues a one-clock reset pulse and records it in the reset flag. This happens only when reset generation is enabled. After the window ends, the interval stage starts over. Clearing the enable bit stops the watchdog and returns the counter to zero.

Top module: `watchdog_twostage`

## Requirements
- R1: After reset the control word reads 0x0000_0700. The interval code is 7 and every other field is 0. Bits [31:11], [5:4] and [0] always read 0.
- R2: Control word layout: interval code in bits [10:8], enable in bit 7, interrupt enable in bit 6, interrupt flag in bit 3, reset flag in bit 2, reset enable in bit 1, restart in bit 0. With code N, the interrupt flag reads 1 exactly 2^(2N+4) timer clocks after the edge that enabled the counter, and reads 0 one clock earlier.
- R3: The interrupt flag sets whether or not interrupt enable is set. `irq` is high only while the flag and interrupt enable are both 1, and it rises together with the flag.
- R4: If the counter is not restarted and reset enable is 1, `sys_rst` is high for exactly one clock. This happens 1024 timer clocks after the interrupt flag set, and the reset flag reads 1 in the same clock.
- R5: With reset enable 0, the end of the grace window produces no `sys_rst` pulse and leaves the reset flag at 0.
- R6: While enable is 0 the counter holds at zero and no flag is set. Re-enabling starts a full interval.
- R7: An unlocked write with bit 0 set clears the counter and cancels a running grace window, so the next flag comes a full interval later. Bit 0 reads back as 0.
- R8: A write with `unlock` low leaves the interval code, enable, interrupt enable and reset enable unchanged.
- R9: Writing 1 to a flag bit clears that flag whether or not `unlock` is high. Writing 0 to a flag bit leaves it unchanged.
- R10: When a flag-setting event and a write-1 clear of that flag fall in the same clock, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Write data |
| unlock | input | 1 | High level permits writes to the protected fields |
| reg_rd_data | output | 32 | Current control word |
| irq | output | 1 | Interrupt request, registered |
| sys_rst | output | 1 | One-clock system reset pulse, registered |

## Verification
The counter is run with interval codes 0 and 1, interrupts enabled and disabled, and reset generation enabled and disabled. The flag is sampled one clock before and exactly at the expected edge, which separates an off-by-one interval from a correct one and shows that `irq` is gated by its enable. A restart issued inside the grace window shows whether the window is truly cancelled: no reset pulse may appear where one otherwise would. Locked writes that attempt to disable the counter, and flag clears timed onto a set edge, separate the lock exemption and the set-over-clear priority from a naive register.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int CTL_W   = 32;
  localparam int SEL_W   = 3;
  localparam int SEL_LSB = 8;
  localparam int EN_BIT  = 7;
  localparam int IE_BIT  = 6;
  localparam int IF_BIT  = 3;
  localparam int RF_BIT  = 2;
  localparam int RE_BIT  = 1;
  localparam int RS_BIT  = 0;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             en;
    logic             ie;
    logic             rsten;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_limit_sel.sv
// Maps the exponent code onto the terminal count of the interval stage.
module wdt_limit_sel #(
  parameter int SEL_W    = 3,
  parameter int EXP_BASE = 4,
  parameter int EXP_STEP = 2,
  parameter int CNT_W    = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] limit_m1
);
  localparam int CODES = 2 ** SEL_W;

  logic [CNT_W-1:0] lut [CODES];

  for (genvar g = 0; g < CODES; g++) begin : g_lut
    localparam int SH = EXP_BASE + EXP_STEP * g;
    assign lut[g] = CNT_W'((64'd1 << SH) - 64'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) limit_m1 <= lut[CODES-1];
    else     limit_m1 <= lut[sel];
  end
endmodule

// File: rtl/wdt_regs.sv
// Control word: protected configuration fields, W1C flags, registered irq.
module wdt_regs
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             unlock,
  input  logic             if_set,
  input  logic             rf_set,
  output wdt_cfg_t         cfg,
  output logic             restart,
  output logic [CTL_W-1:0] rd_data,
  output logic             irq
);
  wdt_cfg_t cfg_q, cfg_nxt;
  logic     if_q, if_nxt;
  logic     rf_q, rf_nxt;
  logic     wr_ok;

  assign wr_ok = wr_en & unlock;

  always_comb begin
    cfg_nxt = cfg_q;
    if (wr_ok) begin
      cfg_nxt.sel   = wr_data[SEL_LSB +: SEL_W];
      cfg_nxt.en    = wr_data[EN_BIT];
      cfg_nxt.ie    = wr_data[IE_BIT];
      cfg_nxt.rsten = wr_data[RE_BIT];
    end
    // set events win over a simultaneous clear
    if_nxt = if_set | (if_q & ~(wr_en & wr_data[IF_BIT]));
    rf_nxt = rf_set | (rf_q & ~(wr_en & wr_data[RF_BIT]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q.sel   <= '1;
      cfg_q.en    <= 1'b0;
      cfg_q.ie    <= 1'b0;
      cfg_q.rsten <= 1'b0;
      if_q        <= 1'b0;
      rf_q        <= 1'b0;
      irq         <= 1'b0;
    end else begin
      cfg_q <= cfg_nxt;
      if_q  <= if_nxt;
      rf_q  <= rf_nxt;
      irq   <= if_nxt & cfg_nxt.ie;
    end
  end

  assign cfg     = cfg_q;
  assign restart = wr_ok & wr_data[RS_BIT];

  always_comb begin
    rd_data                      = '0;
    rd_data[SEL_LSB +: SEL_W]    = cfg_q.sel;
    rd_data[EN_BIT]              = cfg_q.en;
    rd_data[IE_BIT]              = cfg_q.ie;
    rd_data[IF_BIT]              = if_q;
    rd_data[RF_BIT]              = rf_q;
    rd_data[RE_BIT]              = cfg_q.rsten;
  end
endmodule

// File: rtl/wdt_counter.sv
// Shared counter: interval stage, then grace window stage.
module wdt_counter #(
  parameter int CNT_W = 19,
  parameter int GRACE = 1024
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             restart,
  input  logic             rsten,
  input  logic [CNT_W-1:0] limit_m1,
  output logic             tout_evt,
  output logic             expire_evt,
  output logic             sys_rst
);
  localparam logic [CNT_W-1:0] GRACE_M1 = CNT_W'(GRACE - 1);

  logic [CNT_W-1:0] cnt;
  logic             in_grace;
  logic             run;

  assign run        = en & ~restart;
  assign tout_evt   = run & ~in_grace & (cnt >= limit_m1);
  assign expire_evt = run & in_grace & (cnt == GRACE_M1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      in_grace <= 1'b0;
    end else if (tout_evt) begin
      cnt      <= '0;
      in_grace <= 1'b1;
    end else if (expire_evt) begin
      cnt      <= '0;
      in_grace <= 1'b0;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sys_rst <= 1'b0;
    else     sys_rst <= expire_evt & rsten;
  end
endmodule

// File: rtl/watchdog_twostage.sv
module watchdog_twostage
  import wdt_pkg::*;
#(
  parameter int EXP_BASE = 4,
  parameter int EXP_STEP = 2,
  parameter int GRACE    = 1024
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wr_data,
  input  logic        unlock,
  output logic [31:0] reg_rd_data,
  output logic        irq,
  output logic        sys_rst
);
  localparam int IVL_W = EXP_BASE + EXP_STEP * (2 ** SEL_W - 1) + 1;
  localparam int GR_W  = $clog2(GRACE) + 1;
  localparam int CNT_W = (IVL_W > GR_W) ? IVL_W : GR_W;

  wdt_cfg_t         cfg;
  logic             restart;
  logic             tout_evt;
  logic             expire_evt;
  logic [CNT_W-1:0] limit_m1;

  wdt_regs u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_wr_en),
    .wr_data (reg_wr_data),
    .unlock  (unlock),
    .if_set  (tout_evt),
    .rf_set  (expire_evt & cfg.rsten),
    .cfg     (cfg),
    .restart (restart),
    .rd_data (reg_rd_data),
    .irq     (irq)
  );

  wdt_limit_sel #(
    .SEL_W    (SEL_W),
    .EXP_BASE (EXP_BASE),
    .EXP_STEP (EXP_STEP),
    .CNT_W    (CNT_W)
  ) u_limit (
    .clk      (clk),
    .rst      (rst),
    .sel      (cfg.sel),
    .limit_m1 (limit_m1)
  );

  wdt_counter #(
    .CNT_W (CNT_W),
    .GRACE (GRACE)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .en         (cfg.en),
    .restart    (restart),
    .rsten      (cfg.rsten),
    .limit_m1   (limit_m1),
    .tout_evt   (tout_evt),
    .expire_evt (expire_evt),
    .sys_rst    (sys_rst)
  );
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr_en,
  input logic [31:0] reg_wr_data,
  input logic        unlock,
  input logic [31:0] reg_rd_data,
  input logic        irq,
  input logic        sys_rst
);
  p_rst_one_clk_r4: assert property (@(posedge clk) disable iff (rst)
    sys_rst |=> !sys_rst);

  p_rst_flag_r4: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> reg_rd_data[2]);

  p_rst_needs_en_r5: assert property (@(posedge clk) disable iff (rst)
    sys_rst |-> $past(reg_rd_data[1]));

  p_irq_gate_r3: assert property (@(posedge clk) disable iff (rst)
    irq |-> (reg_rd_data[3] && reg_rd_data[6]));

  p_locked_cfg_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !unlock) |=> ($stable(reg_rd_data[10:6]) && $stable(reg_rd_data[1])));

  p_restart_reads_zero_r7: assert property (@(posedge clk) disable iff (rst)
    reg_rd_data[0] == 1'b0);

  p_idle_no_flag_r6: assert property (@(posedge clk) disable iff (rst)
    !reg_rd_data[7] |=> !$rose(reg_rd_data[3]));

  p_w0_keeps_flag_r9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr_en && !reg_wr_data[3] && reg_rd_data[3]) |=> reg_rd_data[3]);
endmodule

bind watchdog_twostage wdt_chk u_wdt_chk (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .unlock      (unlock),
  .reg_rd_data (reg_rd_data),
  .irq         (irq),
  .sys_rst     (sys_rst)
);

// File: tb/tb_watchdog_twostage.sv
module tb_watchdog_twostage;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr_en = 1'b0;
  logic [31:0] reg_wr_data = '0;
  logic        unlock = 1'b0;
  logic [31:0] reg_rd_data;
  logic        irq;
  logic        sys_rst;

  always #2.5 clk = ~clk;

  watchdog_twostage dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .unlock(unlock), .reg_rd_data(reg_rd_data), .irq(irq), .sys_rst(sys_rst)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [33:0] m;
    logic [33:0] v;
    string       req;
  } item_t;
  item_t q[$];
  int checks = 0;
  int errors = 0;
  wire [33:0] obs = {sys_rst, irq, reg_rd_data};

  // monitor: scores every item due at this clock
  always @(negedge clk) begin
    if (!rst) begin
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due <= cyc) begin
          checks++;
          if (q[i].due < cyc || (obs & q[i].m) != (q[i].v & q[i].m)) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %h expected %h (mask %h)",
                     q[i].req, cyc, obs & q[i].m, q[i].v & q[i].m, q[i].m);
          end
          q.delete(i);
        end
      end
    end
  end

  task automatic exp_bit(input int due, input int pos, input logic val, input string req);
    item_t it;
    it.due = due; it.m = 34'd1 << pos; it.v = 34'(val) << pos; it.req = req;
    q.push_back(it);
  endtask

  task automatic exp_rd(input int due, input logic [31:0] val, input string req);
    item_t it;
    it.due = due; it.m = {2'b00, 32'hFFFF_FFFF}; it.v = {2'b00, val}; it.req = req;
    q.push_back(it);
  endtask

  task automatic wait_to(input int n);
    while (cyc < n) begin
      @(posedge clk); #1;
    end
  endtask

  // the write is captured at the clock edge that makes cyc equal edge_no
  task automatic wr_at(input int edge_no, input logic [31:0] d, input logic u);
    wait_to(edge_no - 1);
    reg_wr_en = 1'b1; reg_wr_data = d; unlock = u;
    @(posedge clk); #1;
    reg_wr_en = 1'b0; reg_wr_data = '0; unlock = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
    finish_run();
  end

  initial begin
    int e, b, c, r, r2, dis;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(posedge clk); #1;

    // R1 reset state
    exp_rd(cyc + 1, 32'h0000_0700, "R1");
    exp_bit(cyc + 1, 32, 1'b0, "R1");
    exp_bit(cyc + 1, 33, 1'b0, "R1");

    // code 0 (16 clocks), interrupts and reset disabled
    e = cyc + 3;
    wr_at(e, 32'h0000_0080, 1'b1);
    exp_bit(e + 15, 3, 1'b0, "R2");
    exp_bit(e + 16, 3, 1'b1, "R2");
    exp_bit(e + 16, 32, 1'b0, "R3");
    wr_at(e + 20, 32'h0000_0000, 1'b0);
    exp_bit(e + 20, 7, 1'b1, "R8");
    exp_bit(e + 20, 3, 1'b1, "R9");
    wr_at(e + 22, 32'h0000_0008, 1'b0);
    exp_bit(e + 22, 3, 1'b0, "R9");
    exp_bit(e + 22, 7, 1'b1, "R9");
    exp_bit(e + 1040, 33, 1'b0, "R5");
    exp_bit(e + 1041, 33, 1'b0, "R5");
    exp_bit(e + 1041, 2, 1'b0, "R5");
    exp_bit(e + 1055, 3, 1'b0, "R2");
    exp_bit(e + 1056, 3, 1'b1, "R2");

    // disable and clear: counter idles
    b = e + 1060;
    wr_at(b, 32'h0000_0008, 1'b1);
    exp_rd(b, 32'h0000_0000, "R6");
    exp_rd(b + 40, 32'h0000_0000, "R6");
    wait_to(b + 40);

    // code 1 (64 clocks), interrupt and reset enabled
    c = b + 42;
    wr_at(c, 32'h0000_01C2, 1'b1);
    exp_bit(c + 63, 3, 1'b0, "R2");
    exp_bit(c + 63, 32, 1'b0, "R3");
    exp_bit(c + 64, 3, 1'b1, "R2");
    exp_bit(c + 64, 32, 1'b1, "R3");
    exp_bit(c + 1087, 33, 1'b0, "R4");
    exp_bit(c + 1088, 33, 1'b1, "R4");
    exp_bit(c + 1088, 2, 1'b1, "R4");
    exp_bit(c + 1089, 33, 1'b0, "R4");
    wr_at(c + 1100, 32'h0000_000C, 1'b0);
    exp_bit(c + 1100, 3, 1'b0, "R9");
    exp_bit(c + 1100, 2, 1'b0, "R9");
    exp_bit(c + 1100, 32, 1'b0, "R3");

    // restart, then restart again inside the grace window
    r = c + 1120;
    wr_at(r, 32'h0000_01C3, 1'b1);
    exp_bit(r, 0, 1'b0, "R7");
    exp_bit(r + 63, 3, 1'b0, "R7");
    exp_bit(r + 64, 3, 1'b1, "R7");
    r2 = r + 564;
    wr_at(r2, 32'h0000_01C3, 1'b1);
    exp_bit(r + 1088, 33, 1'b0, "R7");
    exp_bit(r + 1089, 33, 1'b0, "R7");
    exp_bit(r + 1089, 2, 1'b0, "R7");

    // set-over-clear priority
    wr_at(r2 + 10, 32'h0000_0008, 1'b0);
    exp_bit(r2 + 10, 3, 1'b0, "R9");
    wr_at(r2 + 64, 32'h0000_0008, 1'b0);
    exp_bit(r2 + 64, 3, 1'b1, "R10");

    // disable before the next grace window ends
    wait_to(r + 1090);
    dis = r + 1095;
    wr_at(dis, 32'h0000_0000, 1'b1);
    exp_rd(dis, 32'h0000_0008, "R6");
    exp_bit(dis + 600, 33, 1'b0, "R6");
    wait_to(dis + 602);

    repeat (2) @(posedge clk);
    if (q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule